// File: doc/BRIEF.md
# I2C Master Command and Receive Queue Stage

This block sits between a register interface and the bit-level engine of an I2C master. Software pushes 11-bit command words into a transmit queue. Each word carries a payload byte, a read-request flag, a flag asking for a STOP after the byte, and a flag asking for a repeated START before it. The engine takes the command at the head of the queue through a valid/ready handshake. Bytes that the engine receives are stored in a receive queue, and software pops them through a read port.

Both queue fill levels are visible at all times. Two threshold inputs set when the transmit-low condition and the receive-ready condition are raised.

An enable request is applied only while the engine reports no command in progress, and a separate status output shows the state that was actually reached. While that status is low, and on any abort pulse from the engine, both queues are emptied.

Top module: `i2cq_frontend`

## Requirements
- R1: A command word holds the payload in bits 7:0, a read request in bit 8, STOP-after in bit 9 and RESTART-before in bit 10. At the head of the queue these appear on `cmd_data`, `cmd_read`, `cmd_stop` and `cmd_restart`. When bit 8 is set, `cmd_data` reads as 0 whatever the payload bits hold.
- R2: `tx_level` and `rx_level` equal the number of entries held, from 0 up to DEPTH (8 by default).
- R3: A write while the transmit queue holds DEPTH entries is discarded. `tx_ovf` is high for the one cycle after such a write.
- R4: A pop while the receive queue is empty leaves the queue unchanged and returns `rd_data` = 0. `rx_unf` is high for the one cycle after such a pop.
- R5: After a cycle with `abort` high, both levels are 0. Any push made in that same cycle is lost.
- R6: `tx_empty_irq` is high exactly when `tx_level` <= `tx_thr`.
- R7: `rx_full_irq` is high exactly when `rx_level` > `rx_thr`, so a threshold of 0 raises it once one byte is held.
- R8: `enable_stat` takes the value of `enable_req` at a clock edge where `eng_busy` is low, and holds its value at any edge where `eng_busy` is high. It is 0 after reset.
- R9: While `enable_stat` is 0, both queues are cleared at each edge, writes are lost and `cmd_valid` stays 0.
- R10: `cmd_valid` is high when enabled and the transmit queue is not empty. The head leaves on a cycle with `cmd_valid` and `cmd_ready` both high. Commands leave in write order, and an offered command stays unchanged until it is taken.
- R11: Received bytes pushed with `rx_valid` are returned on `rd_data` in arrival order, and `rd_en` removes the head. A byte that arrives while the receive queue is full is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push a command word |
| wr_cmd | input | 11 | Command word |
| rd_en | input | 1 | Pop a received byte |
| rd_data | output | 8 | Head of the receive queue, 0 when empty |
| tx_thr | input | LW | Transmit-low threshold |
| rx_thr | input | LW | Receive-ready threshold |
| enable_req | input | 1 | Requested enable state |
| enable_stat | output | 1 | Enable state actually in force |
| tx_level | output | LW | Transmit queue fill level |
| rx_level | output | LW | Receive queue fill level |
| tx_empty_irq | output | 1 | Transmit level at or below threshold |
| rx_full_irq | output | 1 | Receive level above threshold |
| tx_ovf | output | 1 | Pulse after a write to a full queue |
| rx_unf | output | 1 | Pulse after a pop from an empty queue |
| cmd_valid | output | 1 | Command offered to the engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_data | output | 8 | Payload byte (0 for reads) |
| cmd_read | output | 1 | Read request |
| cmd_stop | output | 1 | STOP after this byte |
| cmd_restart | output | 1 | RESTART before this byte |
| eng_busy | input | 1 | Engine has a command in progress |
| rx_valid | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| abort | input | 1 | Transmit abort pulse, empties both queues |

LW is $clog2(DEPTH+1).

## Verification
The assertions assume that the engine lowers `cmd_ready`, or raises `abort`, on its own terms, and that it may deliver received bytes in any cycle. They do not assume that the engine waits for `cmd_valid`. The hold property on an offered command applies only when no abort arrives and the enable request stays high. The stimulus drives every input at the falling edge from a seeded random source, with aborts and disables kept rare. Directed phases hold `eng_busy` high across an enable request, overfill the transmit queue, and pop the empty receive queue.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

    // Command word layout; bit order is the programming model.
    typedef struct packed {
        logic       restart;   // bit 10
        logic       stop;      // bit 9
        logic       rd;        // bit 8
        logic [7:0] data;      // bits 7:0
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    // Payload shown to the engine: read requests carry no data.
    function automatic logic [7:0] cmd_payload(cmd_t c);
        return c.rd ? 8'h00 : c.data;
    endfunction

endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [LW-1:0]    cnt;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    // R2: occupancy never exceeds the storage
    p_level_bound_r2: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    // R3: a push into a full queue with no pop leaves it full, no wrap
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/i2cq_enable.sv
module i2cq_enable (
    input  logic clk,
    input  logic rst,
    input  logic en_req,
    input  logic eng_busy,
    output logic en_stat
);
    always_ff @(posedge clk) begin
        if (rst)            en_stat <= 1'b0;
        else if (!eng_busy) en_stat <= en_req;
    end

    // R8: state only moves while the engine is idle
    p_en_hold_r8: assert property (@(posedge clk) disable iff (rst)
        eng_busy |=> $stable(en_stat));

endmodule

// File: rtl/i2cq_frontend.sv
module i2cq_frontend #(
    parameter int DEPTH = 8,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [10:0]   wr_cmd,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    input  logic [LW-1:0] tx_thr,
    input  logic [LW-1:0] rx_thr,
    input  logic          enable_req,
    output logic          enable_stat,
    output logic [LW-1:0] tx_level,
    output logic [LW-1:0] rx_level,
    output logic          tx_empty_irq,
    output logic          rx_full_irq,
    output logic          tx_ovf,
    output logic          rx_unf,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [7:0]    cmd_data,
    output logic          cmd_read,
    output logic          cmd_stop,
    output logic          cmd_restart,
    input  logic          eng_busy,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          abort
);
    import i2cq_pkg::*;

    cmd_t       tx_head;
    logic [7:0] rx_head;
    logic       tx_full, tx_empty, rx_full, rx_empty;
    logic       flush_all;

    i2cq_enable u_en (
        .clk     (clk),
        .rst     (rst),
        .en_req  (enable_req),
        .eng_busy(eng_busy),
        .en_stat (enable_stat)
    );

    assign flush_all = abort || !enable_stat;

    i2cq_fifo #(.DEPTH(DEPTH), .WIDTH(CMD_W)) u_txq (
        .clk  (clk),
        .rst  (rst),
        .flush(flush_all),
        .push (wr_en),
        .din  (wr_cmd),
        .pop  (cmd_valid && cmd_ready),
        .dout (tx_head),
        .level(tx_level),
        .full (tx_full),
        .empty(tx_empty)
    );

    i2cq_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
        .clk  (clk),
        .rst  (rst),
        .flush(flush_all),
        .push (rx_valid),
        .din  (rx_byte),
        .pop  (rd_en),
        .dout (rx_head),
        .level(rx_level),
        .full (rx_full),
        .empty(rx_empty)
    );

    assign cmd_valid    = enable_stat && !tx_empty;
    assign cmd_data     = cmd_payload(tx_head);
    assign cmd_read     = tx_head.rd;
    assign cmd_stop     = tx_head.stop;
    assign cmd_restart  = tx_head.restart;
    assign rd_data      = rx_empty ? 8'h00 : rx_head;
    assign tx_empty_irq = (tx_level <= tx_thr);
    assign rx_full_irq  = (rx_level > rx_thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ovf <= 1'b0;
            rx_unf <= 1'b0;
        end else begin
            tx_ovf <= wr_en && tx_full;
            rx_unf <= rd_en && rx_empty;
        end
    end

    // R5: an abort leaves both queues empty on the next cycle
    p_abort_flush_r5: assert property (@(posedge clk) disable iff (rst)
        abort |=> (tx_level == '0) && (rx_level == '0));

    // R9: a disabled block holds nothing after the edge
    p_disabled_empty_r9: assert property (@(posedge clk) disable iff (rst)
        !enable_stat |=> (tx_level == '0) && (rx_level == '0));

    // R4: an underflow pulse is always caused by a pop
    p_unf_cause_r4: assert property (@(posedge clk) disable iff (rst)
        rx_unf |-> $past(rd_en));

    // R10: an offered command is held until the engine takes it
    p_hold_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready && !abort && enable_req) |=>
            (cmd_valid && $stable(cmd_data) && $stable(cmd_read)
             && $stable(cmd_stop) && $stable(cmd_restart)));

endmodule

// File: tb/i2cq_frontend_test.sv
`timescale 1ns/1ps
module i2cq_frontend_test;
    localparam int DEPTH = 8;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, rd_en = 0, cmd_ready = 0, eng_busy = 0;
    logic rx_valid = 0, abort = 0, enable_req = 0;
    logic [10:0] wr_cmd = '0;
    logic [7:0]  rx_byte = '0;
    logic [LW-1:0] tx_thr = '0, rx_thr = '0;
    logic [7:0] rd_data, cmd_data;
    logic enable_stat, tx_empty_irq, rx_full_irq, tx_ovf, rx_unf;
    logic cmd_valid, cmd_read, cmd_stop, cmd_restart;
    logic [LW-1:0] tx_level, rx_level;

    always #2.5 clk = ~clk;

    i2cq_frontend #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd), .rd_en(rd_en),
        .rd_data(rd_data), .tx_thr(tx_thr), .rx_thr(rx_thr),
        .enable_req(enable_req), .enable_stat(enable_stat),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_empty_irq(tx_empty_irq), .rx_full_irq(rx_full_irq),
        .tx_ovf(tx_ovf), .rx_unf(rx_unf), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_data(cmd_data), .cmd_read(cmd_read),
        .cmd_stop(cmd_stop), .cmd_restart(cmd_restart), .eng_busy(eng_busy),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .abort(abort)
    );

    int n_checks = 0;
    int n_fail = 0;

    logic [10:0] txq[$];
    logic [7:0]  rxq[$];
    bit exp_en = 0, exp_ovf = 0, exp_unf = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_payload(logic [10:0] c);
        return c[8] ? 0 : int'(c[7:0]);
    endfunction

    // One cycle: drive at the falling edge, check, then update the model.
    task automatic cycle(input bit wr, input logic [10:0] cmd, input bit rd,
                         input bit rxp, input logic [7:0] rxb, input bit rdy,
                         input bit ab, input bit busy, input bit enq);
        int txs, rxs;
        wr_en = wr; wr_cmd = cmd; rd_en = rd; rx_valid = rxp; rx_byte = rxb;
        cmd_ready = rdy; abort = ab; eng_busy = busy; enable_req = enq;
        #1;
        txs = txq.size();
        rxs = rxq.size();
        chk("R2 tx_level", int'(tx_level), txs);
        chk("R2 rx_level", int'(rx_level), rxs);
        chk("R6 tx_empty_irq", int'(tx_empty_irq), int'(txs <= int'(tx_thr)));
        chk("R7 rx_full_irq", int'(rx_full_irq), int'(rxs > int'(rx_thr)));
        chk("R9 R10 cmd_valid", int'(cmd_valid), int'(exp_en && txs > 0));
        if (txs > 0) begin
            chk("R1 cmd_data", int'(cmd_data), exp_payload(txq[0]));
            chk("R1 cmd_read", int'(cmd_read), int'(txq[0][8]));
            chk("R1 cmd_stop", int'(cmd_stop), int'(txq[0][9]));
            chk("R1 cmd_restart", int'(cmd_restart), int'(txq[0][10]));
        end
        chk("R4 R11 rd_data", int'(rd_data), rxs > 0 ? int'(rxq[0]) : 0);
        chk("R3 tx_ovf", int'(tx_ovf), int'(exp_ovf));
        chk("R4 rx_unf", int'(rx_unf), int'(exp_unf));
        chk("R8 enable_stat", int'(enable_stat), int'(exp_en));
        exp_ovf = wr && (txs == DEPTH);
        exp_unf = rd && (rxs == 0);
        if (ab || !exp_en) begin
            txq.delete();
            rxq.delete();
        end else begin
            if (txs > 0 && rdy) void'(txq.pop_front());
            if (wr && txs < DEPTH) txq.push_back(cmd);
            if (rd && rxs > 0) void'(rxq.pop_front());
            if (rxp && rxs < DEPTH) rxq.push_back(rxb);
        end
        if (!busy) exp_en = enq;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R8 reset enable_stat", int'(enable_stat), 0);
        chk("R2 reset tx_level", int'(tx_level), 0);
        chk("R10 reset cmd_valid", int'(cmd_valid), 0);

        // R9: writes while disabled are lost
        tx_thr = LW'(2);
        rx_thr = '0;
        cycle(1, 11'h0A5, 0, 1, 8'h11, 0, 0, 0, 0);
        cycle(0, '0, 0, 0, '0, 0, 0, 1, 1);   // R8: busy blocks the enable
        cycle(0, '0, 0, 0, '0, 0, 0, 1, 1);
        cycle(0, '0, 0, 0, '0, 0, 0, 0, 1);   // now it takes effect
        // R3: overfill the transmit queue, R1 read request with payload bits
        for (int i = 0; i < DEPTH + 2; i++)
            cycle(1, {1'b1, 1'b0, 1'(i % 2), 8'hC0 + 8'(i)}, 0, 0, '0, 0, 0, 0, 1);
        cycle(0, '0, 0, 0, '0, 0, 0, 0, 1);
        // R4: pop the empty receive queue; R7 with threshold 0
        cycle(0, '0, 1, 0, '0, 0, 0, 0, 1);
        cycle(0, '0, 0, 1, 8'h5A, 0, 0, 0, 1);
        cycle(0, '0, 0, 0, '0, 0, 0, 0, 1);
        // R10: drain in order
        for (int i = 0; i < DEPTH + 1; i++)
            cycle(0, '0, 0, 0, '0, 1, 0, 0, 1);
        // R5: abort with both queues holding data, push in same cycle lost
        cycle(1, 11'h123, 0, 1, 8'h77, 0, 0, 0, 1);
        cycle(1, 11'h124, 0, 1, 8'h78, 0, 1, 0, 1);
        cycle(0, '0, 0, 0, '0, 0, 0, 0, 1);

        // Random traffic with varied thresholds
        for (int ph = 0; ph < 4; ph++) begin
            tx_thr = LW'($urandom_range(0, DEPTH));
            rx_thr = LW'($urandom_range(0, DEPTH - 1));
            for (int k = 0; k < 1500; k++) begin
                bit wr, rd, rxp, rdy, ab, busy, enq;
                wr   = ($urandom_range(0, 99) < 55);
                rdy  = ($urandom_range(0, 99) < (ph % 2 ? 30 : 60));
                rxp  = ($urandom_range(0, 99) < 50);
                rd   = ($urandom_range(0, 99) < (ph % 2 ? 55 : 35));
                ab   = ($urandom_range(0, 299) == 0);
                busy = ($urandom_range(0, 99) < 30);
                enq  = ($urandom_range(0, 199) != 0);
                cycle(wr, 11'($urandom), rd, rxp, 8'($urandom), rdy, ab, busy, enq);
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule